// File: doc/BRIEF.md
# Page-Aware Store Retirement Buffer

This block sits between a write-through processor and a DRAM-style memory. It queues processor stores in a small first-in, first-out buffer. It retires them to memory one at a time, in the order they arrived. How long a retirement takes depends on page locality. A store that falls in the same page as the previously retired store takes the short fast-path time. Any other store pays the longer row-open cost. The first store after a memory read also pays the longer cost, because the read leaves no page open.

Processor reads share the memory port with the drain. A read is served ahead of any queued store that has not started yet. A store that has already started always runs to completion first. Suppose a read targets an address that still sits in the queue. The read then waits until that store has retired, so it never sees stale data. When every entry is taken, a new store is held off with a stall until an entry frees. Memory timing is modelled by internal cycle counters. Each operation shows on a request/write-enable/address/data group of outputs, with a done pulse in its final cycle.

Top module: `page_wbuf`

## Requirements
- R1: After reset the queue is empty, `mem_req_o` is low and no stall is raised; the queue accepts up to DEPTH (default 6) stores without stalling.
- R2: A store presented while DEPTH entries are occupied raises `st_stall_o` and is not taken until an entry frees; `st_stall_o` is never high without `st_valid_i`.
- R3: Stores reach memory in strict arrival order, each with its own address and data, with no merging.
- R4: A store whose page (address bits above PAGE_BITS, default 12) equals that of the previous retired store holds `mem_req_o`/`mem_we_o` for FAST_CYC (default 1) cycles.
- R5: A store to a different page, or the first store after reset, holds the memory port for SLOW_CYC (default 5) cycles.
- R6: The first store retired after a read holds the port for SLOW_CYC cycles even if it is in the page of the store retired before the read.
- R7: A read that is pending when the memory port frees is started before any queued store that has not begun.
- R8: A read arriving while a store is in progress waits for it; an operation once started keeps its address and data stable until its done cycle.
- R9: A read whose address equals a queued store's address is not started until that store has retired.
- R10: A read holds `mem_req_o` high with `mem_we_o` low for RD_CYC cycles, with `mem_done_o` in the last of them; the CPU keeps `rd_valid_i` high until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_valid_i | input | 1 | Store request from the processor |
| st_addr_i | input | AW | Store address |
| st_data_i | input | DW | Store data |
| st_stall_o | output | 1 | Store cannot be taken this cycle |
| rd_valid_i | input | 1 | Read request, held until its done pulse |
| rd_addr_i | input | AW | Read address |
| mem_req_o | output | 1 | Memory operation in progress |
| mem_we_o | output | 1 | Current operation is a store |
| mem_addr_o | output | AW | Address of the current operation |
| mem_wdata_o | output | DW | Data of the current store |
| mem_done_o | output | 1 | Last cycle of the current operation |

## Verification
The bench builds the block with a 10-bit address, 8-bit data and 16-byte pages. Page changes are therefore cheap to produce. It keeps the default six entries and five-cycle slow path, and uses a two-cycle read. With that setup, all 64 patterns of same/new page across a burst of six stores can be swept. Each retirement time is predicted from the previous retired page. The small queue fills within a few slow retirements, which brings the stall boundary within reach. Short reads let the bench place a read mid-store, ahead of queued stores, and behind a matching queued address in a handful of cycles.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2
  } mem_op_e;
endpackage

// File: rtl/page_wbuf_fifo.sv
module page_wbuf_fifo #(
  parameter int DEPTH = 6,
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int PGLSB = 12,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [AW-1:0]   push_addr_i,
  input  logic [DW-1:0]   push_data_i,
  input  logic            pop_i,
  input  logic [AW-1:0]   probe_addr_i,
  output logic            full_o,
  output logic            empty_o,
  output logic [CW-1:0]   fill_o,
  output logic [AW-1:0]   head_addr_o,
  output logic [DW-1:0]   head_data_o,
  output logic [AW-PGLSB-1:0] nxt_pg_o,
  output logic            probe_hit_o
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit_v;
  logic [PW-1:0]    hd_q, tl_q;
  logic [CW-1:0]    fill_q;
  logic [AW-1:0]    nxt_addr;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      addr_q[tl_q] <= push_addr_i;
      data_q[tl_q] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      hd_q   <= '0;
      tl_q   <= '0;
      fill_q <= '0;
    end else begin
      if (pop_i) begin
        vld_q[hd_q] <= 1'b0;
        hd_q        <= ptr_inc(hd_q);
      end
      if (push_i) begin
        vld_q[tl_q] <= 1'b1;
        tl_q        <= ptr_inc(tl_q);
      end
      case ({push_i, pop_i})
        2'b10:   fill_q <= fill_q + CW'(1);
        2'b01:   fill_q <= fill_q - CW'(1);
        default: fill_q <= fill_q;
      endcase
    end
  end

  // slot being retired this cycle no longer blocks a read
  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign hit_v[i] = vld_q[i] && (addr_q[i] == probe_addr_i) &&
                      !(pop_i && (hd_q == PW'(i)));
  end

  assign nxt_addr    = addr_q[ptr_inc(hd_q)];
  assign nxt_pg_o    = nxt_addr[AW-1:PGLSB];
  assign probe_hit_o = |hit_v;
  assign full_o      = (fill_q == CW'(DEPTH));
  assign empty_o     = (fill_q == '0);
  assign fill_o      = fill_q;
  assign head_addr_o = addr_q[hd_q];
  assign head_data_o = data_q[hd_q];
endmodule

// File: rtl/page_wbuf_page.sv
module page_wbuf_page #(
  parameter int PGW = 20
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           set_i,
  input  logic [PGW-1:0] set_pg_i,
  input  logic           clr_i,
  input  logic [PGW-1:0] cand_pg_i,
  output logic           fast_o
);
  logic           open_vld_q;
  logic [PGW-1:0] open_pg_q;
  logic           eff_vld;
  logic [PGW-1:0] eff_pg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_vld_q <= 1'b0;
      open_pg_q  <= '0;
    end else if (clr_i) begin
      open_vld_q <= 1'b0;
    end else if (set_i) begin
      open_vld_q <= 1'b1;
      open_pg_q  <= set_pg_i;
    end
  end

  // a store retiring this cycle defines the page for a back-to-back start
  assign eff_vld = set_i | open_vld_q;
  assign eff_pg  = set_i ? set_pg_i : open_pg_q;
  assign fast_o  = eff_vld && (eff_pg == cand_pg_i);
endmodule

// File: rtl/page_wbuf_engine.sv
module page_wbuf_engine
  import page_wbuf_pkg::*;
#(
  parameter int FAST_CYC = 1,
  parameter int SLOW_CYC = 5,
  parameter int RD_CYC   = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    rd_req_i,
  input  logic    wr_avail_i,
  input  logic    wr_fast_i,
  output mem_op_e op_o,
  output logic    done_o,
  output logic    start_rd_o
);
  localparam int MAXC = (SLOW_CYC > RD_CYC) ? SLOW_CYC : RD_CYC;
  localparam int CTW  = $clog2(MAXC + 1);

  mem_op_e        op_q;
  logic [CTW-1:0] cnt_q;
  logic           done, free, start_rd, start_wr;

  always_comb begin
    done     = (op_q != OP_IDLE) && (cnt_q == '0);
    free     = (op_q == OP_IDLE) || done;
    start_rd = free && rd_req_i && (op_q != OP_RD);
    start_wr = free && !start_rd && wr_avail_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_IDLE;
      cnt_q <= '0;
    end else if (start_rd) begin
      op_q  <= OP_RD;
      cnt_q <= CTW'(RD_CYC - 1);
    end else if (start_wr) begin
      op_q  <= OP_WR;
      cnt_q <= wr_fast_i ? CTW'(FAST_CYC - 1) : CTW'(SLOW_CYC - 1);
    end else if (done) begin
      op_q  <= OP_IDLE;
    end else if (op_q != OP_IDLE) begin
      cnt_q <= cnt_q - CTW'(1);
    end
  end

  assign op_o       = op_q;
  assign done_o     = done;
  assign start_rd_o = start_rd;
endmodule

// File: rtl/page_wbuf.sv
module page_wbuf
  import page_wbuf_pkg::*;
#(
  parameter int DEPTH     = 6,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PAGE_BITS = 12,
  parameter int FAST_CYC  = 1,
  parameter int SLOW_CYC  = 5,
  parameter int RD_CYC    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic [DW-1:0] st_data_i,
  output logic          st_stall_o,
  input  logic          rd_valid_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_done_o
);
  localparam int PGW = AW - PAGE_BITS;
  localparam int CW  = $clog2(DEPTH + 1);

  logic           full, empty, push, pop, probe_hit;
  logic [CW-1:0]  fill;
  logic [AW-1:0]  head_addr, rd_addr_q;
  logic [DW-1:0]  head_data;
  logic [PGW-1:0] nxt_pg, cand_pg;
  logic           wr_avail, wr_fast, done, start_rd;
  mem_op_e        op;

  assign push     = st_valid_i && !full;
  assign pop      = done && (op == OP_WR);
  assign wr_avail = pop ? (fill >= CW'(2)) : !empty;
  assign cand_pg  = pop ? nxt_pg : head_addr[AW-1:PAGE_BITS];

  page_wbuf_fifo #(
    .DEPTH(DEPTH), .AW(AW), .DW(DW), .PGLSB(PAGE_BITS)
  ) u_fifo (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_addr_i  (st_addr_i),
    .push_data_i  (st_data_i),
    .pop_i        (pop),
    .probe_addr_i (rd_addr_i),
    .full_o       (full),
    .empty_o      (empty),
    .fill_o       (fill),
    .head_addr_o  (head_addr),
    .head_data_o  (head_data),
    .nxt_pg_o     (nxt_pg),
    .probe_hit_o  (probe_hit)
  );

  page_wbuf_page #(.PGW(PGW)) u_page (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (pop),
    .set_pg_i  (head_addr[AW-1:PAGE_BITS]),
    .clr_i     (start_rd),
    .cand_pg_i (cand_pg),
    .fast_o    (wr_fast)
  );

  page_wbuf_engine #(
    .FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC), .RD_CYC(RD_CYC)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_req_i   (rd_valid_i && !probe_hit),
    .wr_avail_i (wr_avail),
    .wr_fast_i  (wr_fast),
    .op_o       (op),
    .done_o     (done),
    .start_rd_o (start_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_addr_q <= '0;
    else if (start_rd) rd_addr_q <= rd_addr_i;
  end

  assign st_stall_o  = st_valid_i && full;
  assign mem_req_o   = (op != OP_IDLE);
  assign mem_we_o    = (op == OP_WR);
  assign mem_addr_o  = (op == OP_WR) ? head_addr : rd_addr_q;
  assign mem_wdata_o = (op == OP_WR) ? head_data : '0;
  assign mem_done_o  = done;
endmodule

// File: rtl/page_wbuf_chk.sv
module page_wbuf_chk #(
  parameter int DEPTH    = 6,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int SLOW_CYC = 5,
  parameter int RD_CYC   = 2,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          st_valid_i,
  input logic          st_stall_i,
  input logic          mem_req_i,
  input logic          mem_we_i,
  input logic [AW-1:0] mem_addr_i,
  input logic [DW-1:0] mem_wdata_i,
  input logic          mem_done_i,
  input logic [CW-1:0] fill_i
);
  logic [15:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cyc_q <= '0;
    else if (mem_req_i && !mem_done_i) cyc_q <= cyc_q + 16'd1;
    else                              cyc_q <= '0;
  end

  // R1
  fill_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i <= CW'(DEPTH));

  // R2
  stall_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_stall_i |-> (st_valid_i && fill_i == CW'(DEPTH)));

  // R8
  write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i && !mem_done_i) |=>
      (mem_req_i && mem_we_i && $stable(mem_addr_i) && $stable(mem_wdata_i)));

  // R10
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i && !mem_done_i) |=>
      (mem_req_i && !mem_we_i && $stable(mem_addr_i)));

  // R5
  write_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && mem_we_i) |-> (cyc_q < 16'(SLOW_CYC)));

  // R10
  read_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_i && !mem_we_i) |-> (cyc_q < 16'(RD_CYC)));
endmodule

bind page_wbuf page_wbuf_chk #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .SLOW_CYC(SLOW_CYC), .RD_CYC(RD_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_stall_i  (st_stall_o),
  .mem_req_i   (mem_req_o),
  .mem_we_i    (mem_we_o),
  .mem_addr_i  (mem_addr_o),
  .mem_wdata_i (mem_wdata_o),
  .mem_done_i  (mem_done_o),
  .fill_i      (fill)
);

// File: tb/page_wbuf_bench.sv
`timescale 1ns/1ps
module page_wbuf_bench;
  localparam int DEPTH = 6, AW = 10, DW = 8, PB = 4;
  localparam int FASTC = 1, SLOWC = 5, RDC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 1'b0, rd_valid = 1'b0;
  logic [AW-1:0] st_addr = '0, rd_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_stall, mem_req, mem_we, mem_done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #2.5 clk = ~clk;

  page_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PAGE_BITS(PB),
              .FAST_CYC(FASTC), .SLOW_CYC(SLOWC), .RD_CYC(RDC)) u_page_wbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_addr_i(st_addr), .st_data_i(st_data),
    .st_stall_o(st_stall), .rd_valid_i(rd_valid), .rd_addr_i(rd_addr),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_done_o(mem_done));

  int checks = 0, fails = 0;
  bit finished = 0;
  int mq_a [0:1023];
  int mq_d [0:1023];
  int mq_h = 0, mq_t = 0;
  int wdur = 0, rdur = 0, wr_dones = 0, rd_dones = 0;
  bit pv = 0, after_rd = 0;
  int ppg = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model of retirement order and timing
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we)  wdur++;
      if (mem_req && !mem_we) rdur++;
      if (mem_done && mem_we) begin
        int pg, exp;
        string rq;
        pg  = int'(mem_addr) >> PB;
        exp = (pv && pg == ppg) ? FASTC : SLOWC;
        rq  = (exp == FASTC) ? "R4" : (after_rd ? "R6" : "R5");
        chk(wdur == exp, rq, "store duration", wdur, exp);
        if (mq_h == mq_t) chk(0, "R3", "unexpected store", int'(mem_addr), -1);
        else begin
          chk(int'(mem_addr) == mq_a[mq_h], "R3", "store address", int'(mem_addr), mq_a[mq_h]);
          chk(int'(mem_wdata) == mq_d[mq_h], "R3", "store data", int'(mem_wdata), mq_d[mq_h]);
          mq_h++;
        end
        wdur = 0; pv = 1; ppg = pg; after_rd = 0; wr_dones++;
      end else if (mem_done) begin
        chk(rdur == RDC, "R10", "read duration", rdur, RDC);
        rdur = 0; pv = 0; after_rd = 1; rd_dones++;
      end
    end
  end

  task automatic do_store(input int a, input int d, output int waits);
    st_valid = 1'b1; st_addr = AW'(a); st_data = DW'(d);
    waits = 0;
    #0.2;
    while (st_stall) begin
      waits++;
      @(negedge clk); #1;
    end
    @(posedge clk);
    mq_a[mq_t] = a; mq_d[mq_t] = d; mq_t++;
    @(negedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_write_busy();
    while (!(mem_req && mem_we)) begin @(negedge clk); #1; end
  endtask

  task automatic do_read(input int a, output int delta);
    int w0, r0;
    w0 = wr_dones; r0 = rd_dones;
    rd_valid = 1'b1; rd_addr = AW'(a);
    while (rd_dones == r0) begin @(negedge clk); #1; end
    rd_valid = 1'b0;
    delta = wr_dones - w0;
  endtask

  task automatic drain();
    while (mq_h != mq_t || mem_req) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int w, dl, stalls, pg;
    repeat (3) @(negedge clk);
    chk(mem_req == 1'b0, "R1", "mem_req in reset", int'(mem_req), 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(mem_req == 1'b0, "R1", "mem_req after reset", int'(mem_req), 0);
    chk(st_stall == 1'b0, "R1", "stall after reset", int'(st_stall), 0);

    // R4 R5: every same/new page pattern over six back-to-back stores
    pg = 1;
    for (int pat = 0; pat < 64; pat++) begin
      for (int i = 0; i < 6; i++) begin
        if (pat[i]) pg = (pg + 1) & 63;
        do_store((pg << PB) | i, (pat * 6 + i) & 255, w);
      end
    end
    drain();

    // R1 R2: six distinct-page stores fit, the seventh stalls
    stalls = 0;
    for (int i = 0; i < 8; i++) begin
      do_store(((10 + i) << PB) | 1, 100 + i, w);
      if (i < 6) chk(w == 0, "R1", "stall within capacity", w, 0);
      if (i == 6) chk(w > 0, "R2", "stall when full", w, 1);
      stalls += w;
    end
    chk(stalls > 0, "R2", "total stall cycles", stalls, 1);
    drain();

    // R7 R8: read during a store, ahead of three queued same-page stores
    for (int i = 0; i < 4; i++) do_store((30 << PB) | i, 50 + i, w);
    wait_write_busy();
    do_read((40 << PB) | 2, dl);
    chk(dl == 1, "R8", "stores retired before read", dl, 1);
    drain();
    chk(wr_dones > 0, "R7", "queue drained after read", int'(mq_h == mq_t), 1);

    // R9: read matching the second queued store waits for it
    do_store((20 << PB) | 1, 7, w);
    do_store((21 << PB) | 3, 8, w);
    do_store((21 << PB) | 5, 9, w);
    wait_write_busy();
    do_read((21 << PB) | 3, dl);
    chk(dl == 2, "R9", "stores retired before hazard read", dl, 2);
    drain();

    // R10: read with empty queue starts at once
    do_read(5, dl);
    chk(dl == 0, "R10", "stores during idle read", dl, 0);
    drain();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule